// File: doc/BRIEF.md
# Timebase Prescaler with Test Bypass

The block turns one fast reference clock into two single-cycle clock-enable pulses for downstream timers. A divide-by-7 stage produces a 1 MHz tick from a 7 MHz reference, and a decade chain that counts those ticks produces a 10 Hz tick. Both pulses are plain enables in the reference clock domain. No derived clocks are generated. The reference is taken to be synchronous with the system clock, so the block contains no clock-domain crossing.

A test input serves bench and production test. While it is high, both divider counters are cleared to their starting count and both tick outputs are driven high on every cycle, so the timers they feed run at the full reference rate. When test is released, division restarts from a known phase. The two divide ratios are parameters: `FAST_DIV` defaults to 7 and `SLOW_DIV` defaults to 100000, which gives a 17-bit second counter.

Top module: `timebase_prescaler`

## Requirements
- R1: While rst_ni is low, tick_fast_o and tick_slow_o are both low and both counters are cleared. After release, counting starts from zero.
- R2: With test_i low, tick_fast_o is high for exactly one cycle in every FAST_DIV cycles. The first pulse falls on the FAST_DIV-th cycle after reset release.
- R3: With test_i low, tick_slow_o is high for exactly one cycle in every FAST_DIV*SLOW_DIV cycles. The first pulse falls on the (FAST_DIV*SLOW_DIV)-th cycle after reset release.
- R4: The second stage advances only on fast ticks, so a slow tick always coincides with a fast tick.
- R5: In every cycle where test_i is high, both tick outputs are high.
- R6: test_i high clears both counters, whatever their phase was on entry. After release, the first fast tick falls on the FAST_DIV-th cycle and the first slow tick on the (FAST_DIV*SLOW_DIV)-th cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_i | input | 1 | Test mode: clears the dividers and forces both ticks high |
| tick_fast_o | output | 1 | Single-cycle enable at reference/FAST_DIV |
| tick_slow_o | output | 1 | Single-cycle enable at reference/(FAST_DIV*SLOW_DIV) |

## Verification
Neither counter can be read directly, so its state is only visible through the spacing of the ticks. A wrong count in the first stage moves the next fast tick within FAST_DIV cycles. A wrong count in the second stage shows only at the next slow tick, up to FAST_DIV*SLOW_DIV cycles later. For this reason the bench runs with a short second stage and enters test mode at arbitrary phases. It then checks that the restart phase after release is exact, which exposes any leftover counter state.

// File: rtl/timebase_pkg.sv
package timebase_pkg;
  localparam int unsigned NUM_STAGES = 2;

  function automatic int unsigned cnt_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/prescale_stage.sv
module prescale_stage import timebase_pkg::*; #(
  parameter int unsigned DIV = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tc_o
);
  localparam int unsigned W = cnt_w(DIV);
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;
  logic         at_last;

  assign at_last = (cnt_q == LAST);
  assign tc_o    = en_i & at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (en_i)    cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tick_mux.sv
module tick_mux (
  input  logic rst_ni,
  input  logic test_i,
  input  logic tc_i,
  output logic tick_o
);
  // bypass wins over division; reset holds tick low
  assign tick_o = rst_ni & (test_i | tc_i);
endmodule

// File: rtl/timebase_prescaler.sv
module timebase_prescaler import timebase_pkg::*; #(
  parameter int unsigned FAST_DIV = 7,
  parameter int unsigned SLOW_DIV = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic test_i,
  output logic tick_fast_o,
  output logic tick_slow_o
);
  localparam int unsigned DIVS [NUM_STAGES] = '{FAST_DIV, SLOW_DIV};

  logic [NUM_STAGES-1:0] en;
  logic [NUM_STAGES-1:0] tc;
  logic [NUM_STAGES-1:0] tick;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign en[g] = 1'b1;
    end else begin : g_chain
      assign en[g] = tc[g-1];
    end

    prescale_stage #(.DIV(DIVS[g])) u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (test_i),
      .en_i  (en[g]),
      .tc_o  (tc[g])
    );

    tick_mux u_mux (
      .rst_ni(rst_ni),
      .test_i(test_i),
      .tc_i  (tc[g]),
      .tick_o(tick[g])
    );
  end

  assign tick_fast_o = tick[0];
  assign tick_slow_o = tick[1];
endmodule

// File: rtl/timebase_prescaler_chk.sv
module timebase_prescaler_chk import timebase_pkg::*; #(
  parameter int unsigned FAST_DIV = 7,
  parameter int unsigned SLOW_DIV = 100000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic test_i,
  input logic tick_fast_o,
  input logic tick_slow_o
);
  localparam int unsigned FW = cnt_w(FAST_DIV) + 1;
  localparam int unsigned SW = cnt_w(SLOW_DIV) + 1;

  logic [FW-1:0] fgap_q;
  logic [SW-1:0] sgap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fgap_q <= '0;
      sgap_q <= '0;
    end else if (test_i) begin
      fgap_q <= '0;
      sgap_q <= '0;
    end else if (tick_fast_o) begin
      fgap_q <= '0;
      sgap_q <= tick_slow_o ? '0 : sgap_q + 1'b1;
    end else begin
      fgap_q <= fgap_q + 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !tick_fast_o && !tick_slow_o);
  // R5
  test_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i |-> tick_fast_o && tick_slow_o);
  // R4
  slow_in_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_slow_o |-> tick_fast_o);
  // R2
  fast_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_fast_o && !test_i) |-> fgap_q == FW'(FAST_DIV - 1));
  // R2
  fast_no_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fgap_q < FW'(FAST_DIV));
  // R3
  slow_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_slow_o && !test_i) |-> sgap_q == SW'(SLOW_DIV - 1));
  // R6
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(test_i) |-> (FAST_DIV == 1) || !tick_fast_o);
endmodule

bind timebase_prescaler timebase_prescaler_chk #(
  .FAST_DIV(FAST_DIV),
  .SLOW_DIV(SLOW_DIV)
) u_chk (.*);

// File: tb/tb_timebase_prescaler.sv
module tb_timebase_prescaler;
  localparam int unsigned F = 7;
  localparam int unsigned S = 10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic test_i = 1'b0;
  logic tick_fast_o, tick_slow_o;

  typedef struct {
    logic  fast;
    logic  slow;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_err = 0;
  int   pf = 0;
  int   ps = 0;
  int   since_test = -1;
  bit   done = 1'b0;

  always #10 clk_i = ~clk_i;

  timebase_prescaler #(.FAST_DIV(F), .SLOW_DIV(S)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .test_i(test_i),
    .tick_fast_o(tick_fast_o), .tick_slow_o(tick_slow_o)
  );

  task automatic cyc(input bit r, input bit t);
    exp_t e;
    @(posedge clk_i);
    #1;
    rst_ni = r;
    test_i = t;
    if (!r) begin
      e = '{1'b0, 1'b0, "R1"};
      pf = 0; ps = 0; since_test = -1;
    end else if (t) begin
      e = '{1'b1, 1'b1, "R5"};
      pf = 0; ps = 0; since_test = 0;
    end else begin
      e.fast = (pf == F - 1);
      e.slow = e.fast && (ps == S - 1);
      if (since_test >= 0 && since_test < int'(F * S)) e.tag = "R6";
      else if (e.slow) e.tag = "R3";
      else if (e.fast) e.tag = "R4";
      else e.tag = "R2";
      if (since_test >= 0) since_test++;
      if (e.fast) begin
        pf = 0;
        ps = (ps == S - 1) ? 0 : ps + 1;
      end else begin
        pf++;
      end
    end
    q.push_back(e);
  endtask

  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (tick_fast_o !== e.fast || tick_slow_o !== e.slow) begin
        n_err++;
        $display("FAIL %s: fast/slow act=%b%b exp=%b%b", e.tag,
                 tick_fast_o, tick_slow_o, e.fast, e.slow);
      end
    end
  end

  task automatic run(input int n, input bit t);
    for (int i = 0; i < n; i++) cyc(1'b1, t);
  endtask

  initial begin
    cyc(1'b0, 1'b0); cyc(1'b0, 1'b1); cyc(1'b0, 1'b0);  // R1 incl. test during reset
    run(300, 1'b0);   // R2 R3 R4
    run(5, 1'b1);     // R5
    run(160, 1'b0);   // R6
    run(3, 1'b0);
    run(1, 1'b1);     // R6 single-cycle test at odd phase
    run(150, 1'b0);
    run(37, 1'b0);
    cyc(1'b0, 1'b0); cyc(1'b0, 1'b0);                   // R1 mid-run reset
    run(100, 1'b0);
    @(posedge clk_i);
    @(negedge clk_i);
    #1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule